// File: doc/BRIEF.md
# Six-bit bidirectional GPIO port controller

The block drives and samples six general purpose pins. A small register bus reaches two registers: an output latch that feeds the pins, and a direction register that turns each pin's driver on or off. Reading the port register returns the synchronized pin levels, not the latch. A separate bit command sets or clears one bit as a read-modify-write: it samples what the port register reads, changes one bit, and loads all six bits into the latch.

Side inputs change how each pin behaves. Bit 3 is input only. Pins marked in the analog-select mask read as 0. A master-clear-enable flag hides bit 3 on reads. A crystal oscillator code forces pins 5 and 4 to be inputs. Each override is applied when the register is read or the driver enable is formed. The stored direction bits are never altered, so when an override is released the written value takes effect again.

Top module: `gpio6_port`

## Requirements
- R1: After reset the latch holds 0, every direction bit reads 1 (direction register reads 0x3F) and every output enable is 0.
- R2: For each pin, the output enable equals the inverse of its effective direction bit (1 = input). The pin output always carries the latch bit.
- R3: With reg_addr = 0 (port register), bus_rdata[5:0] returns the pin levels through a two-flop synchronizer. A pin change set up before one rising edge appears after the second rising edge and not after the first.
- R4: A bus write with reg_addr = 0 loads bus_wdata[5:0] into the latch, visible on pin_out after that edge. A write with reg_addr = 1 loads the direction register.
- R5: bus_rdata[7:6] read 0 for both registers, whatever was written to those bits.
- R6: Bit 3 is input only: pin_oe[3] is always 0 and direction bit 3 always reads 1.
- R7: When mclr_en = 1, port register bit 3 reads 0.
- R8: A pin whose ana_mask bit is 1 reads 0 on the port register. Its output enable still follows its direction bit.
- R9: osc_code values 0, 1 and 2 are crystal modes. In these modes direction bits 5:4 read 1 and pin_oe[5:4] are 0. Codes 3 to 7 leave those pins under direction register control.
- R10: A cycle with bit_req = 1 loads the latch with the current port register read value, with bit bit_idx set (bit_set = 1) or cleared (bit_set = 0). For bit_idx 6 or 7 the read value is loaded unchanged.
- R11: A port register write and a bit command in the same cycle load the latch from the bus write. The bit command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 port/latch, 1 direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| bit_req | input | 1 | Single-bit read-modify-write command |
| bit_set | input | 1 | 1 sets, 0 clears the addressed bit |
| bit_idx | input | 3 | Bit addressed by the command |
| pin_in | input | 6 | Pin levels from the pads |
| pin_out | output | 6 | Latch value driven toward the pads |
| pin_oe | output | 6 | Per-pin output driver enable |
| ana_mask | input | 6 | 1 marks a pin as analog |
| mclr_en | input | 1 | Master-clear enable; hides bit 3 on reads |
| osc_code | input | 3 | Oscillator mode code |

## Verification
The assertions assume that the side inputs (ana_mask, mclr_en, osc_code) change only between clock edges. They also assume that the bus holds steady for the whole cycle in which a write or bit command is sampled. The bench sets every input at the falling edge and holds it across the next rising edge. It changes the side inputs only while no write is in flight. It then waits several cycles before comparing any read value, so the synchronizer has settled.

// File: rtl/gpio6_port.sv
module gpio6_port #(
  parameter int PORT_W = 6,
  parameter int BUS_W = 8,
  parameter int IDX_W = 3,
  parameter int OSC_W = 3,
  parameter int IN_ONLY_BIT = 3,
  parameter int XTAL_CODES = 3,
  parameter logic [PORT_W-1:0] XTAL_PINS = 6'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              bit_req,
  input  logic              bit_set,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  input  logic [PORT_W-1:0] ana_mask,
  input  logic              mclr_en,
  input  logic [OSC_W-1:0]  osc_code
);
  localparam logic [PORT_W-1:0] IN_ONLY_M = PORT_W'(1) << IN_ONLY_BIT;
  localparam int PAD_W = BUS_W - PORT_W;

  logic [PORT_W-1:0] sync1_q, sync2_q, lat_q, dir_q;
  logic [PORT_W-1:0] dir_eff, hide, port_rd, bit_mask, rmw;
  logic xtal, port_wr, dir_wr;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[BUS_W-1:PORT_W];

  assign xtal     = osc_code < OSC_W'(XTAL_CODES);
  assign dir_eff  = dir_q | IN_ONLY_M | (xtal ? XTAL_PINS : '0);
  assign hide     = ana_mask | (mclr_en ? IN_ONLY_M : '0);
  assign port_rd  = sync2_q & ~hide;
  assign bit_mask = (int'(bit_idx) < PORT_W) ? (PORT_W'(1) << bit_idx) : '0;
  assign rmw      = bit_set ? (port_rd | bit_mask) : (port_rd & ~bit_mask);
  assign port_wr  = bus_we && !reg_addr;
  assign dir_wr   = bus_we && reg_addr;

  assign pin_out   = lat_q;
  assign pin_oe    = ~dir_eff;
  assign bus_rdata = {PAD_W'(0), reg_addr ? dir_eff : port_rd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      lat_q   <= '0;
      dir_q   <= '1;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (port_wr)      lat_q <= bus_wdata[PORT_W-1:0];
      else if (bit_req) lat_q <= rmw;
      if (dir_wr)       dir_q <= bus_wdata[PORT_W-1:0];
    end
  end

  // R6
  in_only_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe[IN_ONLY_BIT]);

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:PORT_W] == '0);

  // R9
  xtal_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xtal |-> (pin_oe & XTAL_PINS) == '0);

  // R8
  analog_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> (bus_rdata[PORT_W-1:0] & ana_mask) == '0);

  // R7
  mclr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_addr && mclr_en) |-> !bus_rdata[IN_ONLY_BIT]);

  // R4 R11
  port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> pin_out == $past(bus_wdata[PORT_W-1:0]));

  // R6
  dir_bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> bus_rdata[IN_ONLY_BIT]);
endmodule

// File: tb/sim_gpio6_port.sv
module sim_gpio6_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // fields: dir, lat, pin, ana, mclr, osc, exp_oe, exp_port_rd, exp_dir_rd
  localparam logic [45:0] VEC [NV] = '{
    {6'h00, 6'h2A, 6'h15, 6'h00, 1'b0, 3'd7, 6'h37, 6'h15, 6'h08},
    {6'h3F, 6'h15, 6'h3F, 6'h00, 1'b1, 3'd7, 6'h00, 6'h37, 6'h3F},
    {6'h0F, 6'h30, 6'h2C, 6'h05, 1'b0, 3'd0, 6'h00, 6'h28, 6'h3F},
    {6'h30, 6'h3F, 6'h08, 6'h30, 1'b0, 3'd4, 6'h07, 6'h08, 6'h38},
    {6'h00, 6'h11, 6'h3F, 6'h3F, 1'b1, 3'd2, 6'h07, 6'h00, 6'h38},
    {6'h22, 6'h00, 6'h00, 6'h00, 1'b0, 3'd1, 6'h05, 6'h00, 6'h3A}
  };

  logic clk = 0, rst_n = 0;
  logic reg_addr = 0, bus_we = 0, bit_req = 0, bit_set = 0, mclr_en = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [2:0] bit_idx = 0, osc_code = 3'd7;
  logic [5:0] pin_in = 0, pin_out, pin_oe, ana_mask = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio6_port u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_req(bit_req), .bit_set(bit_set),
    .bit_idx(bit_idx), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ana_mask(ana_mask), .mclr_en(mclr_en), .osc_code(osc_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bitop(logic s, logic [2:0] i);
    bit_set = s; bit_idx = i; bit_req = 1;
    @(negedge clk);
    bit_req = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    reg_addr = a; #1; v = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {2'b0, pin_oe}, 8'h00);
    chk("R1 latch", {2'b0, pin_out}, 8'h00);
    rd(1, v); chk("R1 dir", v, 8'h3F);

    for (int k = 0; k < NV; k++) begin
      pin_in = VEC[k][33:28]; ana_mask = VEC[k][27:22];
      mclr_en = VEC[k][21]; osc_code = VEC[k][20:18];
      wr(1, {2'b11, VEC[k][45:40]});
      wr(0, {2'b11, VEC[k][39:34]});
      repeat (3) @(negedge clk);
      // R2 R6 R9 R8 oe, R4 latch
      chk("R2/R6/R9 oe", {2'b0, pin_oe}, {2'b0, VEC[k][17:12]});
      chk("R4 pin_out", {2'b0, pin_out}, {2'b0, VEC[k][39:34]});
      // R3 R5 R7 R8 port read
      rd(0, v); chk("R3/R5/R7/R8 port", v, {2'b0, VEC[k][11:6]});
      // R5 R6 R9 direction read
      rd(1, v); chk("R5/R6/R9 dir", v, {2'b0, VEC[k][5:0]});
      @(negedge clk);
    end

    // R3 two-edge latency
    ana_mask = 0; mclr_en = 0; osc_code = 3'd7; pin_in = 6'h00;
    repeat (3) @(negedge clk);
    pin_in = 6'h3F;
    @(negedge clk); rd(0, v); chk("R3 after one edge", v, 8'h00);
    @(negedge clk); rd(0, v); chk("R3 after two edges", v, 8'h3F);

    // R10 read-modify-write from pin levels
    pin_in = 6'h2A; wr(0, 8'h00);
    repeat (3) @(negedge clk);
    bitop(1, 3'd0); chk("R10 set bit0", {2'b0, pin_out}, 8'h2B);
    bitop(0, 3'd1); chk("R10 clear bit1", {2'b0, pin_out}, 8'h28);
    bitop(1, 3'd7); chk("R10 idx 7", {2'b0, pin_out}, 8'h2A);
    ana_mask = 6'h02;
    bitop(1, 3'd0); chk("R10 analog reads 0", {2'b0, pin_out}, 8'h29);
    ana_mask = 0; mclr_en = 1; pin_in = 6'h08;
    repeat (3) @(negedge clk);
    bitop(1, 3'd5); chk("R10 mclr hides bit3", {2'b0, pin_out}, 8'h20);
    mclr_en = 0;

    // R11 bus write beats bit command
    reg_addr = 0; bus_wdata = 8'h05; bus_we = 1;
    bit_req = 1; bit_set = 1; bit_idx = 3'd5;
    @(negedge clk);
    bus_we = 0; bit_req = 0;
    chk("R11 priority", {2'b0, pin_out}, 8'h05);

    // R1 reset again restores directions and latch
    rst_n = 0; #1;
    chk("R1 reset latch", {2'b0, pin_out}, 8'h00);
    rd(1, v); chk("R1 reset dir", v, 8'h3F);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule